// File: doc/BRIEF.md
# Power-Management SMI Status and Range-Decode Register Bank

This block is a small register bank for power management, sitting on a simple synchronous register bus made of an address, a write enable, write data and combinational read data. The window holds one SMI status register and three plain 32-bit control and data registers. A second select input reaches a base/mask pair that is kept apart from the window.

The status register records three causes of a system-management interrupt:
- a VGA-emulation trap on a memory access;
- a VGA-emulation trap on an I/O access;
- the external active-low SMI pin being held low.

Each flag is sticky. Software clears a flag by writing 1 to its bit position.

The range decoder watches a stream of qualified memory addresses. It raises a registered hit flag for any address that matches the base under the mask. A separate packet formatter uses that hit flag as one of its status bits.

The hit output comes from a two-state machine:
- `RH_IDLE` moves to `RH_HIT` on a strobe whose address matches (transition "match").
- `RH_HIT` stays in `RH_HIT` on a further matching strobe (transition "rematch").
- Any other cycle returns the machine to `RH_IDLE` (transition "drop").
- The output `range_hit` is high exactly in `RH_HIT`.

Top module: `pm_status_bank`

## Requirements
- R1: After reset every register reads 0x00000000 and `range_hit` is 0.
- R2: A one-cycle pulse on `evt_vga_mem` sets status bit 2 (window offset 0x8500) at the next clock edge.
- R3: A one-cycle pulse on `evt_vga_io` sets status bit 1 at the next clock edge.
- R4: A clock edge at which `smi_pin_n` is low sets status bit 0.
- R5: Status bits 2:0 stay set until a window write to 0x8500 carries 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R6: If a set event and a write-1 clear reach the same status bit at the same edge, the bit ends up set.
- R7: Status bits 31:3 always read 0 and ignore writes.
- R8: Window offsets 0x8504, 0x8508 and 0x850C are independent 32-bit read/write registers.
- R9: Any other window offset reads 0, and a write to it changes no register.
- R10: With `bus_rng_sel` high, `bus_addr[2]`=0 reaches the base register and `bus_addr[2]`=1 reaches the mask register. Both are 32-bit read/write registers.
- R11: `range_hit` is 1 in the cycle after an edge where `mem_strobe` was high and `(mem_addr & mask) == (base & mask)`. In every other cycle it is 0.
- R12: With the mask at 0, every strobed address is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rng_sel | input | 1 | 1: access base/mask pair; 0: access the window |
| bus_addr | input | 16 | Window offset, or base/mask pick via bit 2 |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| evt_vga_mem | input | 1 | VGA-emulation SMI, memory cause |
| evt_vga_io | input | 1 | VGA-emulation SMI, I/O cause |
| smi_pin_n | input | 1 | External SMI pin, active low |
| mem_strobe | input | 1 | Qualified memory access present |
| mem_addr | input | 32 | Address of the memory access |
| range_hit | output | 1 | Registered range-decode hit |

## Verification
The assertions check the following on every cycle:
- the sticky hold of each flag;
- that a write-1 clear takes effect;
- that a set event wins over a clear at the same edge;
- that `range_hit` only follows a strobe;
- that control, base and mask registers hold when not written;
- that reserved status bits read 0.

Only the bench scenarios can show that the read-back values are correct at each offset. The same holds for unmapped offsets reading 0 without disturbing neighbours, for the exact range-match boundaries, and for the mask-zero case where every strobe hits.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int BUS_AW = 16;
    localparam int DW     = 32;
    localparam int NFLAG  = 3;
    localparam int NCTRL  = 3;
    localparam logic [BUS_AW-1:0] OFS_STAT = 16'h8500;

    typedef enum logic [0:0] {
        RH_IDLE = 1'b0,
        RH_HIT  = 1'b1
    } rh_state_e;

    function automatic logic [BUS_AW-1:0] ctrl_ofs(input int idx);
        return OFS_STAT + BUS_AW'((idx + 1) * 4);
    endfunction
endpackage

// File: rtl/pm_status_flags.sv
module pm_status_flags #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flags_o
);
    for (genvar b = 0; b < NFLAG; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[b] <= 1'b0;
            else if (set_i[b])
                flags_o[b] <= 1'b1;
            else if (clr_i[b])
                flags_o[b] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[b] && !clr_i[b]) |=> flags_o[b]);             // R5
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !flags_o[b]);              // R5
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> flags_o[b]);                              // R6
    end
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs #(
    parameter int DW    = 32,
    parameter int NREG  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          we_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [NREG-1:0][DW-1:0]  data_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_o[i] <= '0;
            else if (we_i[i])
                data_o[i] <= wdata_i;
        end

        AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !we_i[i] |=> $stable(data_o[i]));                      // R8
    end

    AST_CTRL_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_i));                                           // R8
endmodule

// File: rtl/pm_range_match.sv
module pm_range_match #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we_i,
    input  logic          mask_we_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          strobe_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] mask_o,
    output logic          hit_o
);
    import pm_pkg::*;

    rh_state_e state_q, state_d;
    logic      match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o <= '0;
            mask_o <= '0;
        end else begin
            if (base_we_i) base_o <= wdata_i;
            if (mask_we_i) mask_o <= wdata_i;
        end
    end

    assign match = strobe_i && (((addr_i ^ base_o) & mask_o) == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RH_IDLE: state_d = match ? RH_HIT : RH_IDLE;
            RH_HIT:  state_d = match ? RH_HIT : RH_IDLE;
            default: state_d = RH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hit_o = 1'b0;
        unique case (state_q)
            RH_IDLE: hit_o = 1'b0;
            RH_HIT:  hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(strobe_i));                                // R11
    AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !hit_o);                                     // R11
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we_i |=> $stable(base_o));                           // R10
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o));                           // R10
endmodule

// File: rtl/pm_status_bank.sv
module pm_status_bank
    import pm_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rng_sel,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              evt_vga_mem,
    input  logic              evt_vga_io,
    input  logic              smi_pin_n,
    input  logic              mem_strobe,
    input  logic [MEM_AW-1:0] mem_addr,
    output logic              range_hit
);
    logic                      win_we;
    logic                      stat_sel;
    logic [NFLAG-1:0]          flag_set;
    logic [NFLAG-1:0]          flag_clr;
    logic [NFLAG-1:0]          flags;
    logic [NCTRL-1:0]          ctrl_sel;
    logic [NCTRL-1:0][DW-1:0]  ctrl_q;
    logic [MEM_AW-1:0]         base_q;
    logic [MEM_AW-1:0]         mask_q;

    assign win_we   = bus_we && !bus_rng_sel;
    assign stat_sel = (bus_addr == OFS_STAT);
    assign flag_set = {evt_vga_mem, evt_vga_io, !smi_pin_n};
    assign flag_clr = (win_we && stat_sel) ? bus_wdata[NFLAG-1:0] : '0;

    for (genvar i = 0; i < NCTRL; i++) begin : g_sel
        assign ctrl_sel[i] = (bus_addr == ctrl_ofs(i));
    end

    pm_status_flags #(.NFLAG(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    pm_ctrl_regs #(.DW(DW), .NREG(NCTRL)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctrl_sel & {NCTRL{win_we}}),
        .wdata_i (bus_wdata),
        .data_o  (ctrl_q)
    );

    pm_range_match #(.AW(MEM_AW)) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we_i (bus_we && bus_rng_sel && !bus_addr[2]),
        .mask_we_i (bus_we && bus_rng_sel &&  bus_addr[2]),
        .wdata_i   (bus_wdata),
        .strobe_i  (mem_strobe),
        .addr_i    (mem_addr),
        .base_o    (base_q),
        .mask_o    (mask_q),
        .hit_o     (range_hit)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rng_sel) begin
            bus_rdata = bus_addr[2] ? mask_q : base_q;
        end else if (stat_sel) begin
            bus_rdata[NFLAG-1:0] = flags;
        end else begin
            for (int i = 0; i < NCTRL; i++)
                if (ctrl_sel[i]) bus_rdata = ctrl_q[i];
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rng_sel && stat_sel) |-> (bus_rdata[DW-1:NFLAG] == '0)); // R7
    AST_PIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_pin_n |=> (!bus_rng_sel && stat_sel) -> bus_rdata[0]);   // R4
endmodule

// File: tb/tb_pm_status_bank.sv
`timescale 1ns/1ps
module tb_pm_status_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rng_sel = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        evt_vga_mem = 1'b0;
    logic        evt_vga_io = 1'b0;
    logic        smi_pin_n = 1'b1;
    logic        mem_strobe = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        range_hit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pm_status_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_rng_sel(bus_rng_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_vga_mem(evt_vga_mem), .evt_vga_io(evt_vga_io), .smi_pin_n(smi_pin_n),
        .mem_strobe(mem_strobe), .mem_addr(mem_addr), .range_hit(range_hit)
    );

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e, act;
            bit k;
            string t;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            act = k ? {31'b0, range_hit} : bus_rdata;
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, act, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input bit rng, input logic [15:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_rng_sel = rng; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit rng, input logic [15:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_rng_sel = rng; bus_addr = a; bus_we = 1'b0;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    endtask

    task automatic chk_hit(input bit e, input string t);
        @(posedge clk); #1;
        exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    endtask

    task automatic ev(input bit m, input bit io, input bit pin);
        @(posedge clk); #1;
        evt_vga_mem = m; evt_vga_io = io; smi_pin_n = !pin;
        @(posedge clk); #1;
        evt_vga_mem = 1'b0; evt_vga_io = 1'b0; smi_pin_n = 1'b1;
    endtask

    task automatic strobe(input bit v, input logic [31:0] a, input bit e, input string t);
        @(posedge clk); #1;
        mem_strobe = v; mem_addr = a;
        @(posedge clk); #1;
        mem_strobe = 1'b0;
        exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(0, 16'h8500, 32'h0, "R1 status reset");
        rd(0, 16'h8504, 32'h0, "R1 ctrl0 reset");
        rd(0, 16'h850C, 32'h0, "R1 ctrl2 reset");
        rd(1, 16'h0004, 32'h0, "R1 mask reset");
        chk_hit(1'b0, "R1 hit reset");

        ev(1, 0, 0);
        rd(0, 16'h8500, 32'h4, "R2 mem event sets bit2");
        wr(0, 16'h8500, 32'h0);
        rd(0, 16'h8500, 32'h4, "R5 write 0 keeps flag");
        ev(0, 1, 0);
        rd(0, 16'h8500, 32'h6, "R3 io event sets bit1");
        ev(0, 0, 1);
        rd(0, 16'h8500, 32'h7, "R4 pin low sets bit0");
        wr(0, 16'h8500, 32'h4);
        rd(0, 16'h8500, 32'h3, "R5 write 1 clears only bit2");
        wr(0, 16'h8500, 32'h3);
        rd(0, 16'h8500, 32'h0, "R5 write 1 clears bits1:0");

        // R6: mem event and write-1 clear of all flags in the same cycle
        ev(0, 1, 0);
        @(posedge clk); #1;
        bus_rng_sel = 1'b0; bus_addr = 16'h8500; bus_wdata = 32'h7; bus_we = 1'b1;
        evt_vga_mem = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; evt_vga_mem = 1'b0;
        rd(0, 16'h8500, 32'h4, "R6 set wins over clear");
        wr(0, 16'h8500, 32'h4);

        ev(0, 0, 1);
        wr(0, 16'h8500, 32'hFFFF_FFF8);
        rd(0, 16'h8500, 32'h1, "R7 reserved bits read 0");
        wr(0, 16'h8500, 32'h1);

        wr(0, 16'h8504, 32'hA5A5_1234);
        wr(0, 16'h8508, 32'h0F0F_F0F0);
        wr(0, 16'h850C, 32'hDEAD_0001);
        rd(0, 16'h8504, 32'hA5A5_1234, "R8 ctrl0 readback");
        rd(0, 16'h8508, 32'h0F0F_F0F0, "R8 ctrl1 readback");
        rd(0, 16'h850C, 32'hDEAD_0001, "R8 ctrl2 readback");

        wr(0, 16'h8510, 32'h1234_5678);
        wr(0, 16'h84FC, 32'h8765_4321);
        rd(0, 16'h8510, 32'h0, "R9 unmapped reads 0");
        rd(0, 16'h84FC, 32'h0, "R9 unmapped below reads 0");
        rd(0, 16'h850C, 32'hDEAD_0001, "R9 neighbour untouched");
        rd(0, 16'h8500, 32'h0, "R9 status untouched");

        wr(1, 16'h0000, 32'h000A_0000);
        wr(1, 16'h0004, 32'hFFFE_0000);
        rd(1, 16'h0000, 32'h000A_0000, "R10 base readback");
        rd(1, 16'h0004, 32'hFFFE_0000, "R10 mask readback");
        rd(0, 16'h8504, 32'hA5A5_1234, "R10 window untouched");

        strobe(1, 32'h000B_FFF0, 1'b1, "R11 inside range hits");
        chk_hit(1'b0, "R11 hit lasts one cycle");
        strobe(1, 32'h000A_0000, 1'b1, "R11 lower bound hits");
        strobe(1, 32'h000C_0000, 1'b0, "R11 above range misses");
        strobe(1, 32'h0009_FFFF, 1'b0, "R11 below range misses");
        strobe(0, 32'h000A_1000, 1'b0, "R11 no strobe no hit");

        wr(1, 16'h0004, 32'h0);
        strobe(1, 32'hFFFF_FFFF, 1'b1, "R12 mask zero hits all");
        strobe(1, 32'h0000_0000, 1'b1, "R12 mask zero hits zero");

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule